// File: doc/BRIEF.md
# Two-Level Opcode Integer ALU

A purely combinational 32-bit integer arithmetic-logic unit for the execute stage of a simple in-order core. A 4-bit operation code from the main decoder chooses the operation directly. One code value instead hands the choice to the 6-bit function field of a register-format instruction. That field adds nor and three shift kinds on top of the common arithmetic and logic set.

The unit takes two operands (A and B), a 5-bit shift amount, the operation code and the function field. It returns a 32-bit result in the same cycle. Every shift acts on operand B. Immediate extension, operand selection and overflow traps are left to the surrounding datapath. A single adder serves add, subtract and set-less-than. One barrel shifter serves both directions.

Top module: `alu_core`

## Requirements
- R1: Operation code 0 returns operand B unchanged.
- R2: Operation code 2 returns A+B and code 3 returns A-B, both wrapping modulo 2^32 with no other effect.
- R3: Operation codes 4, 5 and 6 return the bitwise and, or and xor of A and B.
- R4: Operation code 7 returns the low 16 bits of B in bits 31:16, with bits 15:0 zero.
- R5: Operation code 8 returns B shifted left logically by the shift amount.
- R6: Operation code 9 returns 1 when A is less than B as signed 32-bit numbers, else 0.
- R7: Operation code 1 with function field 0x20, 0x22, 0x24, 0x25, 0x26, 0x27 or 0x2a returns add, subtract, and, or, xor, nor (~(A|B)) or signed set-less-than respectively.
- R8: Operation code 1 with function field 0x00, 0x02 or 0x03 returns B shifted by the shift amount: left logical, right logical (zero fill), or right arithmetic (copies of bit 31 fill). A shift amount of 0 returns B.
- R9: Operation code 1 with any function field value not listed in R7 or R8 returns zero.
- R10: Operation codes 10 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B; also the shifted value and the load-upper source |
| shamt_i | input | 5 | Shift amount |
| op_i | input | 4 | Operation code |
| funct_i | input | 6 | Function field, used only when op_i is 1 |
| result_o | output | 32 | Result |

## Verification
Whenever the inputs are known, the assertions watch the following properties:
- set-less-than never drives any bit above bit 0;
- load-upper leaves the low half zero;
- the arithmetic right shift keeps the sign of B;
- a zero shift amount leaves the shifter's data untouched;
- a subtraction of equal operands yields zero;
- unlisted function fields and operation codes give zero.

Only the bench's scenarios can show that each code picks the correct operation with correct values. These scenarios include wrap-around at 2^32, signed comparisons across the sign boundary, shift amounts of 0 and 31, and sweeps over every function field and every unused operation code.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W    = 4;
  localparam int FUNCT_W = 6;

  localparam logic [OP_W-1:0] OP_PASS  = 4'd0;
  localparam logic [OP_W-1:0] OP_FUNCT = 4'd1;
  localparam logic [OP_W-1:0] OP_ADD   = 4'd2;
  localparam logic [OP_W-1:0] OP_SUB   = 4'd3;
  localparam logic [OP_W-1:0] OP_AND   = 4'd4;
  localparam logic [OP_W-1:0] OP_OR    = 4'd5;
  localparam logic [OP_W-1:0] OP_XOR   = 4'd6;
  localparam logic [OP_W-1:0] OP_LUI   = 4'd7;
  localparam logic [OP_W-1:0] OP_SHIFT = 4'd8;
  localparam logic [OP_W-1:0] OP_SLT   = 4'd9;

  localparam logic [FUNCT_W-1:0] FN_SLL = 6'h00;
  localparam logic [FUNCT_W-1:0] FN_SRL = 6'h02;
  localparam logic [FUNCT_W-1:0] FN_SRA = 6'h03;
  localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
  localparam logic [FUNCT_W-1:0] FN_XOR = 6'h26;
  localparam logic [FUNCT_W-1:0] FN_NOR = 6'h27;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'h2a;

  typedef enum logic [3:0] {
    K_ZERO, K_PASS, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
    K_LUI, K_SLL, K_SRL, K_SRA, K_SLT
  } alu_kind_e;

  function automatic logic funct_known(logic [FUNCT_W-1:0] f);
    return f inside {FN_SLL, FN_SRL, FN_SRA, FN_ADD, FN_SUB, FN_AND,
                     FN_OR, FN_XOR, FN_NOR, FN_SLT};
  endfunction
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [OP_W-1:0]    op_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output alu_kind_e          kind_o
);
  alu_kind_e funct_kind;

  always_comb begin
    case (funct_i)
      FN_SLL:  funct_kind = K_SLL;
      FN_SRL:  funct_kind = K_SRL;
      FN_SRA:  funct_kind = K_SRA;
      FN_ADD:  funct_kind = K_ADD;
      FN_SUB:  funct_kind = K_SUB;
      FN_AND:  funct_kind = K_AND;
      FN_OR:   funct_kind = K_OR;
      FN_XOR:  funct_kind = K_XOR;
      FN_NOR:  funct_kind = K_NOR;
      FN_SLT:  funct_kind = K_SLT;
      default: funct_kind = K_ZERO;
    endcase
  end

  always_comb begin
    case (op_i)
      OP_PASS:  kind_o = K_PASS;
      OP_FUNCT: kind_o = funct_kind;
      OP_ADD:   kind_o = K_ADD;
      OP_SUB:   kind_o = K_SUB;
      OP_AND:   kind_o = K_AND;
      OP_OR:    kind_o = K_OR;
      OP_XOR:   kind_o = K_XOR;
      OP_LUI:   kind_o = K_LUI;
      OP_SHIFT: kind_o = K_SLL;
      OP_SLT:   kind_o = K_SLT;
      default:  kind_o = K_ZERO;
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         lt_o
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum_o = a_i + b_eff + W'(sub_i);
    // signed less-than; meaningful when sub_i is set
    lt_o  = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : sum_o[W-1];
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i})) begin
      // R2
      sub_self_zero_chk: assert (!(sub_i && a_i == b_i) || sum_o == '0)
        else $error("equal operands did not subtract to zero");
    end
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    data_i,
  input  logic [SH_W-1:0] shamt_i,
  input  logic            right_i,
  input  logic            arith_i,
  output logic [W-1:0]    data_o
);
  logic [W-1:0] rev_in, rev_out;
  logic [W-1:0] stage [SH_W+1];
  logic         fill;

  assign fill = arith_i & right_i & data_i[W-1];

  // left shifts run through the right shifter on bit-reversed data
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = data_i[W-1-i];
    assign rev_out[i] = stage[SH_W][W-1-i];
  end

  assign stage[0] = right_i ? data_i : rev_in;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stage[s+1] = shamt_i[s] ? {{D{fill}}, stage[s][W-1:D]} : stage[s];
  end

  assign data_o = right_i ? stage[SH_W] : rev_out;

  always_comb begin
    if (!$isunknown({data_i, shamt_i, right_i, arith_i})) begin
      // R8
      zero_shift_chk: assert (shamt_i != '0 || data_o == data_i)
        else $error("zero shift amount altered data");
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output logic [DATA_W-1:0]  result_o
);
  localparam int HALF = DATA_W / 2;

  alu_kind_e         kind;
  logic [DATA_W-1:0] sum, shifted;
  logic              lt, sub_en, sh_right, sh_arith;

  alu_decode i_decode (
    .op_i    (op_i),
    .funct_i (funct_i),
    .kind_o  (kind)
  );

  assign sub_en   = (kind == K_SUB) || (kind == K_SLT);
  assign sh_right = (kind == K_SRL) || (kind == K_SRA);
  assign sh_arith = (kind == K_SRA);

  alu_addsub #(.W(DATA_W)) i_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (sub_en),
    .sum_o (sum),
    .lt_o  (lt)
  );

  alu_shifter #(.W(DATA_W), .SH_W(SHAMT_W)) i_shifter (
    .data_i  (b_i),
    .shamt_i (shamt_i),
    .right_i (sh_right),
    .arith_i (sh_arith),
    .data_o  (shifted)
  );

  always_comb begin
    case (kind)
      K_PASS:                result_o = b_i;
      K_ADD, K_SUB:          result_o = sum;
      K_AND:                 result_o = a_i & b_i;
      K_OR:                  result_o = a_i | b_i;
      K_XOR:                 result_o = a_i ^ b_i;
      K_NOR:                 result_o = ~(a_i | b_i);
      K_LUI:                 result_o = {b_i[HALF-1:0], {HALF{1'b0}}};
      K_SLL, K_SRL, K_SRA:   result_o = shifted;
      K_SLT:                 result_o = {{(DATA_W-1){1'b0}}, lt};
      default:               result_o = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, shamt_i, op_i, funct_i})) begin
      // R6
      slt_bool_chk: assert (kind != K_SLT || result_o[DATA_W-1:1] == '0)
        else $error("set-less-than drove upper bits");
      // R4
      lui_low_zero_chk: assert (op_i != OP_LUI || result_o[HALF-1:0] == '0)
        else $error("load-upper low half not zero");
      // R8
      sra_sign_chk: assert (!(op_i == OP_FUNCT && funct_i == FN_SRA) ||
                            result_o[DATA_W-1] == b_i[DATA_W-1])
        else $error("arithmetic shift lost sign");
      // R9
      bad_funct_zero_chk: assert (!(op_i == OP_FUNCT && !funct_known(funct_i)) ||
                                  result_o == '0)
        else $error("unlisted function field gave nonzero");
      // R10
      bad_op_zero_chk: assert (op_i <= OP_SLT || result_o == '0)
        else $error("unused operation code gave nonzero");
    end
  end
endmodule

// File: tb/test_alu_core.sv
module test_alu_core;
  logic        clk = 1'b0;
  logic [31:0] a, b, res;
  logic [4:0]  sh;
  logic [3:0]  op;
  logic [5:0]  fn;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  alu_core i_alu_core (
    .a_i(a), .b_i(b), .shamt_i(sh), .op_i(op), .funct_i(fn), .result_o(res)
  );

  function automatic logic [31:0] ref_fn(logic [5:0] f, logic [31:0] x, logic [31:0] y, logic [4:0] s);
    case (f)
      6'h00: return y << s;
      6'h02: return y >> s;
      6'h03: return $unsigned($signed(y) >>> s);
      6'h20: return x + y;
      6'h22: return x - y;
      6'h24: return x & y;
      6'h25: return x | y;
      6'h26: return x ^ y;
      6'h27: return ~(x | y);
      6'h2a: return {31'd0, $signed(x) < $signed(y)};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] ref_alu(logic [3:0] o, logic [5:0] f, logic [31:0] x, logic [31:0] y, logic [4:0] s);
    case (o)
      4'd0: return y;
      4'd1: return ref_fn(f, x, y, s);
      4'd2: return x + y;
      4'd3: return x - y;
      4'd4: return x & y;
      4'd5: return x | y;
      4'd6: return x ^ y;
      4'd7: return {y[15:0], 16'd0};
      4'd8: return y << s;
      4'd9: return {31'd0, $signed(x) < $signed(y)};
      default: return 32'd0;
    endcase
  endfunction

  task automatic run(input logic [3:0] o, input logic [5:0] f, input logic [31:0] x,
                     input logic [31:0] y, input logic [4:0] s, input string req);
    logic [31:0] exp;
    @(negedge clk);
    op = o; fn = f; a = x; b = y; sh = s;
    exp = ref_alu(o, f, x, y, s);
    @(posedge clk); #1;
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s op=%0d fn=%h a=%h b=%h sh=%0d: got %h expected %h",
               req, o, f, x, y, s, res, exp);
    end
  endtask

  task automatic t_pass();  // R1
    run(4'd0, 6'h20, 32'h1234_5678, 32'hdead_beef, 5'd3, "R1");
    run(4'd0, 6'h00, 32'hffff_ffff, 32'h0, 5'd0, "R1");
  endtask

  task automatic t_addsub();  // R2
    run(4'd2, 6'h0, 32'hffff_ffff, 32'h1, 5'd0, "R2");
    run(4'd2, 6'h0, 32'h7fff_ffff, 32'h1, 5'd0, "R2");
    run(4'd3, 6'h0, 32'h0, 32'h1, 5'd0, "R2");
    run(4'd3, 6'h0, 32'h8000_0000, 32'h1, 5'd0, "R2");
    run(4'd3, 6'h0, 32'h5555_aaaa, 32'h5555_aaaa, 5'd0, "R2");
  endtask

  task automatic t_logic();  // R3
    for (int o = 4; o <= 6; o++) begin
      run(4'(o), 6'h0, 32'hf0f0_cc33, 32'h0ff0_a5a5, 5'd0, "R3");
    end
  endtask

  task automatic t_lui();  // R4
    run(4'd7, 6'h0, 32'hffff_ffff, 32'habcd_1234, 5'd7, "R4");
    run(4'd7, 6'h0, 32'h0, 32'h0000_ffff, 5'd0, "R4");
  endtask

  task automatic t_shift_op();  // R5
    run(4'd8, 6'h3, 32'h0, 32'h8000_0001, 5'd1, "R5");
    run(4'd8, 6'h0, 32'h0, 32'hffff_ffff, 5'd31, "R5");
    run(4'd8, 6'h0, 32'h0, 32'h1234_5678, 5'd0, "R5");
  endtask

  task automatic t_slt();  // R6
    run(4'd9, 6'h0, 32'hffff_ffff, 32'h1, 5'd0, "R6");
    run(4'd9, 6'h0, 32'h1, 32'hffff_ffff, 5'd0, "R6");
    run(4'd9, 6'h0, 32'h8000_0000, 32'h7fff_ffff, 5'd0, "R6");
    run(4'd9, 6'h0, 32'h5, 32'h5, 5'd0, "R6");
    run(4'd9, 6'h0, 32'h4, 32'h5, 5'd0, "R6");
  endtask

  task automatic t_funct_alu();  // R7
    logic [5:0] list [7] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2a};
    for (int i = 0; i < 7; i++) begin
      run(4'd1, list[i], 32'h8000_00ff, 32'h0000_ff0f, 5'd9, "R7");
      run(4'd1, list[i], 32'h0000_0003, 32'hffff_fffd, 5'd0, "R7");
    end
  endtask

  task automatic t_funct_shift();  // R8
    for (int s = 0; s < 32; s += 31) begin
      run(4'd1, 6'h00, 32'h0, 32'h8000_0001, 5'(s), "R8");
      run(4'd1, 6'h02, 32'h0, 32'h8000_0001, 5'(s), "R8");
      run(4'd1, 6'h03, 32'h0, 32'h8000_0001, 5'(s), "R8");
    end
    run(4'd1, 6'h03, 32'h0, 32'hf000_0000, 5'd4, "R8");
    run(4'd1, 6'h03, 32'h0, 32'h7000_0000, 5'd4, "R8");
    run(4'd1, 6'h02, 32'h0, 32'hf000_0000, 5'd17, "R8");
  endtask

  task automatic t_funct_bad();  // R9
    for (int f = 0; f < 64; f++) begin
      if (!(f inside {'h00, 'h02, 'h03, 'h20, 'h22, 'h24, 'h25, 'h26, 'h27, 'h2a}))
        run(4'd1, 6'(f), 32'hffff_ffff, 32'hffff_ffff, 5'd5, "R9");
    end
  endtask

  task automatic t_op_bad();  // R10
    for (int o = 10; o < 16; o++) begin
      run(4'(o), 6'h20, 32'hffff_ffff, 32'h8000_0001, 5'd3, "R10");
    end
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 400; i++) begin
      run(4'($urandom_range(0, 15)),
          (i % 2 == 0) ? 6'($urandom_range(0, 63)) : 6'h2a,
          $urandom, $urandom, 5'($urandom), "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    op = '0; fn = '0; a = '0; b = '0; sh = '0;
    // initial state with all-zero inputs
    @(posedge clk); #1;
    checks++;
    if (res !== 32'd0) begin
      errors++;
      $display("FAIL R1 initial: got %h expected %h", res, 32'd0);
    end
    t_pass();
    t_addsub();
    t_logic();
    t_lui();
    t_shift_op();
    t_slt();
    t_funct_alu();
    t_funct_shift();
    t_funct_bad();
    t_op_bad();
    t_mixed();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule